// File: doc/BRIEF.md
# Multi-master I2C byte controller

This block is a single-byte I2C bus engine. It can act as a bus master or as an addressed slave, and it is steered by a small control word and an 8-bit status word. Software picks one of four roles, enables the serial port, and uses one command bit to request a START or a STOP. As a master, the engine issues a START and then shifts out the data byte at once. It watches for lost arbitration against other masters and records the acknowledge bit that follows the byte. After that it parks the bus, holding SCL low, until software asks for a STOP.

As a slave, the engine collects the first byte after each START and compares its upper seven bits with a programmed own address. It also recognises the all-zero general-call byte. It acknowledges either kind of hit.

SCL and SDA are open-drain. The block only produces pull-low enables and reads the bus levels back through a synchronizer. A divider on the system clock times each SCL half period.

Top module: `i2cb_ctrl`

## Requirements
- R1: After reset the status word reads 0x00 and neither SCL nor SDA is pulled low.
- R2: A control write with mode 10 or 11 (bit 7 = 1), command bit 5 = 1 and enable bit 4 = 1, made while the bus is free, issues a START. The engine then shifts out `tx_data` MSB first, one bit per SCL period, releases SDA for a ninth clock, and afterwards holds SCL low.
- R3: A control write with bit 7 = 1 and bit 5 = 0, made while the master holds the bus after its byte, produces a STOP (SDA rising while SCL is high), which leaves the bus free.
- R4: Status bit 5 (busy) becomes 1 when a START is seen on the bus and 0 when a STOP is seen.
- R5: Status bit 0 holds the SDA level the master sampled on the ninth clock: 0 for ACK, 1 for no ACK.
- R6: If the master releases SDA for a 1 bit but samples it low on the SCL rising edge, it sets status bit 3, stops driving both lines at once, and abandons the transfer. Busy stays 1 until a STOP appears.
- R7: Status bit 3 returns to 0 when the next START request is accepted.
- R8: In mode 00 or 01 with the port enabled, when bits 7:1 of the first byte after a START equal `own_addr`, the engine sets status bit 2 and pulls SDA low on the ninth clock. A byte that matches neither the own address nor the general-call value gets no acknowledge. `rx_data` shows the last address byte received.
- R9: Status bit 2 returns to 0 on the cycle after a `stat_rd` pulse.
- R10: A received first byte of 0x00 sets status bit 1 and is acknowledged. Bit 1 returns to 0 when the next START or STOP is seen.
- R11: With enable bit 4 = 0 the engine pulls neither line low, ignores START requests and leaves addresses unanswered.
- R12: The status word is {mode[1:0], busy, enable, arbitration-lost, own-address hit, general-call hit, last acknowledge bit} from bit 7 down to bit 0. The control write carries the mode in bits 7:6, the command in bit 5 and the enable in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control bits 7:4 (mode, command, enable) |
| stat_rd | input | 1 | Status read strobe; clears the own-address hit |
| own_addr | input | 7 | Own slave address |
| tx_data | input | 8 | Byte sent after a master START |
| status | output | 8 | Status word |
| rx_data | output | 8 | Last address byte received as slave |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that `scl_i` and `sda_i` are the wired-AND of every device on the bus, including this block's own pull-downs. They also assume that each SCL high or low phase lasts longer than the synchronizer delay, and that a status read never lands in the same cycle as an address match while the own-address flag is already set. The bench models the bus as exactly that wired-AND and runs its own master with 20-cycle half periods. It issues status reads only after a byte has finished and writes control words only while the engine is idle or parked.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;

  typedef enum logic [2:0] {
    MS_IDLE, MS_START, MS_LOW, MS_HIGH, MS_HOLD, MS_STPA, MS_STPB
  } mst_e;

  typedef enum logic [1:0] {
    SS_IDLE, SS_ADDR, SS_ACKW, SS_ACK
  } slv_e;
endpackage

// File: rtl/i2cb_busmon.sv
module i2cb_busmon import i2cb_pkg::*; #(
  parameter int SYNC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);
  // index SYNC-1 is the synchronized level, index SYNC the previous one
  logic [SYNC:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC-1:0], scl_i};
      sda_q <= {sda_q[SYNC-1:0], sda_i};
    end
  end

  always_comb begin
    ev.sda   = sda_q[SYNC-1];
    ev.rise  = scl_q[SYNC-1] & ~scl_q[SYNC];
    ev.fall  = ~scl_q[SYNC-1] & scl_q[SYNC];
    ev.start = scl_q[SYNC-1] & scl_q[SYNC] & sda_q[SYNC] & ~sda_q[SYNC-1];
    ev.stop  = scl_q[SYNC-1] & scl_q[SYNC] & ~sda_q[SYNC] & sda_q[SYNC-1];
  end
endmodule

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == '0);

  always_comb begin
    if (restart || tick) cnt_n = CW'(DIV - 1);
    else                 cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master import i2cb_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic              stop_req,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              scl_drv,
  output logic              sda_drv,
  output logic              lost,
  output logic              ack_vld,
  output logic              ack_bit,
  output logic              idle
);
  localparam int CW = $clog2(BYTE_W + 1);

  mst_e              st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              data_ph;

  assign data_ph = (cnt_q < CW'(BYTE_W));
  assign ack_bit = sda_s;
  assign idle    = (st_q == MS_IDLE);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    lost    = 1'b0;
    ack_vld = 1'b0;
    unique case (st_q)
      MS_IDLE:  if (go) begin
                  st_n  = MS_START;
                  cnt_n = '0;
                  sh_n  = tx_byte;
                end
      MS_START: if (tick) st_n = MS_LOW;
      MS_LOW:   if (tick) st_n = MS_HIGH;
      MS_HIGH: begin
        if (scl_rise && data_ph && sh_q[BYTE_W-1] && !sda_s) begin
          lost = 1'b1;
          st_n = MS_IDLE;
        end else begin
          ack_vld = scl_rise && !data_ph;
          if (tick) begin
            if (!data_ph) st_n = MS_HOLD;
            else begin
              cnt_n = cnt_q + 1'b1;
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              st_n  = MS_LOW;
            end
          end
        end
      end
      MS_HOLD:  if (stop_req) st_n = MS_STPA;
      MS_STPA:  if (tick) st_n = MS_STPB;
      MS_STPB:  if (tick) st_n = MS_IDLE;
      default:  st_n = MS_IDLE;
    endcase
  end

  always_comb begin
    scl_drv = (st_q == MS_LOW) || (st_q == MS_HOLD) || (st_q == MS_STPA);
    sda_drv = (st_q == MS_START) || (st_q == MS_STPA) || (st_q == MS_STPB) ||
              (((st_q == MS_LOW) || (st_q == MS_HIGH)) && data_ph && !sh_q[BYTE_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/i2cb_slave.sv
module i2cb_slave import i2cb_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [BYTE_W-2:0] own_addr,
  output logic              sda_drv,
  output logic              hit_own,
  output logic              hit_gc,
  output logic              rx_vld,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW = $clog2(BYTE_W);

  slv_e              st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;

  assign rx_byte = sh_n;
  assign sda_drv = (st_q == SS_ACK);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    hit_own = 1'b0;
    hit_gc  = 1'b0;
    rx_vld  = 1'b0;
    if (!en || bus_stop) begin
      st_n = SS_IDLE;
    end else if (bus_start) begin
      st_n  = SS_ADDR;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        SS_ADDR: if (scl_rise) begin
          sh_n  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CW'(BYTE_W - 1)) begin
            rx_vld  = 1'b1;
            hit_own = (sh_n[BYTE_W-1:1] == own_addr);
            hit_gc  = (sh_n == '0);
            st_n    = (hit_own || hit_gc) ? SS_ACKW : SS_IDLE;
          end
        end
        SS_ACKW: if (scl_fall) st_n = SS_ACK;
        SS_ACK:  if (scl_fall) st_n = SS_IDLE;
        default: st_n = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SS_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl import i2cb_pkg::*; #(
  parameter int DIV  = 250,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:4]        ctl_wdata,
  input  logic              stat_rd,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  bus_ev_t ev;
  logic tick, go, stop_req;
  logic m_scl, m_sda, m_lost, m_ack_vld, m_ack_bit, m_idle;
  logic s_sda, s_own, s_gc, s_vld;
  logic [BYTE_W-1:0] s_byte;

  logic [1:0] mode_q, mode_n;
  logic oe_q, oe_n, busy_q, busy_n, al_q, al_n;
  logic aas_q, aas_n, az_q, az_n, lrb_q, lrb_n;
  logic [BYTE_W-1:0] rx_q, rx_n;

  assign go       = ctl_we && ctl_wdata[7] && ctl_wdata[5] && ctl_wdata[4] && !busy_q && m_idle;
  assign stop_req = ctl_we && ctl_wdata[7] && !ctl_wdata[5];

  i2cb_busmon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst_n(srst_n), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

  i2cb_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(srst_n), .restart(go), .tick(tick));

  i2cb_master u_mst (
    .clk(clk), .rst_n(srst_n), .tick(tick), .go(go), .stop_req(stop_req),
    .scl_rise(ev.rise), .sda_s(ev.sda), .tx_byte(tx_data),
    .scl_drv(m_scl), .sda_drv(m_sda), .lost(m_lost),
    .ack_vld(m_ack_vld), .ack_bit(m_ack_bit), .idle(m_idle));

  i2cb_slave u_slv (
    .clk(clk), .rst_n(srst_n), .en(oe_q && !mode_q[1]),
    .bus_start(ev.start), .bus_stop(ev.stop), .scl_rise(ev.rise),
    .scl_fall(ev.fall), .sda_s(ev.sda), .own_addr(own_addr),
    .sda_drv(s_sda), .hit_own(s_own), .hit_gc(s_gc),
    .rx_vld(s_vld), .rx_byte(s_byte));

  always_comb begin
    mode_n = ctl_we ? ctl_wdata[7:6] : mode_q;
    oe_n   = ctl_we ? ctl_wdata[4]   : oe_q;
    busy_n = ev.start ? 1'b1 : (ev.stop ? 1'b0 : busy_q);
    al_n   = m_lost ? 1'b1 : (go ? 1'b0 : al_q);
    aas_n  = s_own ? 1'b1 : (stat_rd ? 1'b0 : aas_q);
    az_n   = s_gc ? 1'b1 : ((ev.start || ev.stop) ? 1'b0 : az_q);
    lrb_n  = m_ack_vld ? m_ack_bit : lrb_q;
    rx_n   = s_vld ? s_byte : rx_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= '0;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
      al_q   <= 1'b0;
      aas_q  <= 1'b0;
      az_q   <= 1'b0;
      lrb_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      mode_q <= mode_n;
      oe_q   <= oe_n;
      busy_q <= busy_n;
      al_q   <= al_n;
      aas_q  <= aas_n;
      az_q   <= az_n;
      lrb_q  <= lrb_n;
      rx_q   <= rx_n;
    end
  end

  assign status  = {mode_q, busy_q, oe_q, al_q, aas_q, az_q, lrb_q};
  assign rx_data = rx_q;
  assign scl_oe  = oe_q && m_scl;
  assign sda_oe  = oe_q && (m_sda || s_sda);
endmodule

// File: rtl/i2cb_ctrl_chk.sv
module i2cb_ctrl_chk import i2cb_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:4] ctl_wdata,
  input logic       stat_rd,
  input logic [7:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input bus_ev_t    ev
);
  p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> status[5]);

  p_busy_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stop |=> !status[5]);

  p_al_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && status[7]) |-> (!scl_oe && !sda_oe));

  p_aas_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && status[2]) |=> !status[2]);

  p_az_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.start || ev.stop) |=> !status[1]);

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[4]) |=> (!scl_oe && !sda_oe));
endmodule

bind i2cb_ctrl i2cb_ctrl_chk u_chk (
  .clk(clk), .rst_n(srst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .stat_rd(stat_rd), .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ev(ev));

// File: tb/sim_i2cb_ctrl.sv
`timescale 1ns/1ps
module sim_i2cb_ctrl;
  localparam int DIV = 10;
  localparam int H   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:4] ctl_wdata = '0;
  logic stat_rd = 1'b0;
  logic [6:0] own_addr = 7'h2B;
  logic [7:0] tx_data = '0;
  logic [7:0] status, rx_data;
  logic scl_oe, sda_oe, scl_w, sda_w;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0, tb_ack_low = 1'b0, tb_ack_en = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  assign scl_w = !(scl_oe || tb_scl_low);
  assign sda_w = !(sda_oe || tb_sda_low || tb_ack_low);

  i2cb_ctrl #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .stat_rd(stat_rd), .own_addr(own_addr), .tx_data(tx_data),
    .status(status), .rx_data(rx_data), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: collects the first byte after each START, compares with the queue,
  // and plays an acknowledging slave when tb_ack_en is set.
  logic pscl = 1'b1, psda = 1'b1, col = 1'b0;
  int nb = 0, ackph = 0;
  logic [7:0] msh = '0;
  always @(negedge clk) begin
    if (pscl && scl_w && psda && !sda_w) begin
      col = 1'b1; nb = 0; ackph = 0; tb_ack_low = 1'b0;
    end else if (pscl && scl_w && !psda && sda_w) begin
      col = 1'b0; ackph = 0; tb_ack_low = 1'b0;
    end else begin
      if (!pscl && scl_w && col && nb < 8) begin
        msh = {msh[6:0], sda_w};
        nb++;
        if (nb == 8) begin
          if (exp_q.size() == 0) chk("R2 unexpected byte", msh, 8'hxx);
          else chk("R2 byte on bus", msh, exp_q.pop_front());
          ackph = 1;
        end
      end
      if (pscl && !scl_w && ackph == 1) begin
        tb_ack_low = tb_ack_en; ackph = 2;
      end else if (pscl && !scl_w && ackph == 2) begin
        tb_ack_low = 1'b0; ackph = 0; col = 1'b0;
      end
    end
    pscl = scl_w;
    psda = sda_w;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:4] d);
    waitc(1);
    ctl_wdata = d; ctl_we = 1'b1;
    waitc(1);
    ctl_we = 1'b0;
  endtask

  task automatic rd_pulse();
    waitc(1);
    stat_rd = 1'b1;
    waitc(1);
    stat_rd = 1'b0;
  endtask

  task automatic tb_start();
    tb_sda_low = 1'b1; waitc(H);
    tb_scl_low = 1'b1; waitc(H);
  endtask

  task automatic tb_bit(input logic b, output logic s);
    tb_sda_low = !b; waitc(H);
    tb_scl_low = 1'b0; waitc(H);
    @(negedge clk); s = sda_w;
    waitc(1);
    tb_scl_low = 1'b1; waitc(H);
  endtask

  task automatic tb_stop();
    tb_sda_low = 1'b1; waitc(H);
    tb_scl_low = 1'b0; waitc(H);
    tb_sda_low = 1'b0; waitc(H);
  endtask

  task automatic tb_send(input logic [7:0] b, output logic ack);
    logic s;
    exp_q.push_back(b);
    tb_start();
    for (int i = 7; i >= 0; i--) tb_bit(b[i], s);
    tb_bit(1'b1, ack);
  endtask

  task automatic samp_stat(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, status, exp);
  endtask

  logic ack;

  initial begin
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
    // R1 / R12: reset state
    samp_stat("R1 R12 reset status", 8'h00);
    chk("R1 reset drive", {6'd0, scl_oe, sda_oe}, 8'h00);

    // R2 R4 R5: master transmit with ACK
    tb_ack_en = 1'b1; tx_data = 8'hA6; exp_q.push_back(8'hA6);
    wr(4'b1111);
    waitc(300);
    samp_stat("R2 R4 R5 master tx acked", 8'hF0);
    chk("R2 scl held low", {7'd0, scl_oe}, 8'h01);
    wr(4'b1101);
    waitc(60);
    samp_stat("R3 R4 stop frees bus", 8'hD0);

    // R5: no acknowledge
    tb_ack_en = 1'b0; tx_data = 8'h3C; exp_q.push_back(8'h3C);
    wr(4'b1111);
    waitc(300);
    samp_stat("R5 master tx nack", 8'hF1);
    wr(4'b1101);
    waitc(60);
    samp_stat("R3 stop after nack", 8'hD1);

    // R6: arbitration loss on the first 1 bit
    tx_data = 8'hC0;
    wr(4'b1111);
    do @(negedge clk); while (!status[5]);
    waitc(1);
    tb_sda_low = 1'b1;
    waitc(200);
    samp_stat("R6 arbitration lost", 8'hF9);
    chk("R6 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    tb_sda_low = 1'b0;
    waitc(20);
    samp_stat("R6 busy until stop", 8'hD9);

    // R8 R9: own address as slave
    wr(4'b0001);
    tb_send(8'h56, ack);
    chk("R8 own address acked", {7'd0, ack}, 8'h00);
    samp_stat("R8 own hit flag", 8'h3D);
    chk("R8 rx_data", rx_data, 8'h56);
    rd_pulse();
    samp_stat("R9 read clears hit", 8'h39);
    tb_stop();
    samp_stat("R4 slave stop", 8'h19);

    // R10: general call
    tb_send(8'h00, ack);
    chk("R10 general call acked", {7'd0, ack}, 8'h00);
    samp_stat("R10 zero flag set", 8'h3B);
    tb_stop();
    samp_stat("R10 zero flag cleared", 8'h19);

    // R8: mismatch
    tb_send(8'h44, ack);
    chk("R8 mismatch not acked", {7'd0, ack}, 8'h01);
    samp_stat("R8 no flags", 8'h39);
    chk("R8 rx_data mismatch", rx_data, 8'h44);
    tb_stop();

    // R11: port disabled
    wr(4'b0000);
    tb_send(8'h56, ack);
    chk("R11 slave silent", {7'd0, ack}, 8'h01);
    samp_stat("R11 no hit", 8'h29);
    tb_stop();
    wr(4'b1110);
    waitc(100);
    samp_stat("R11 start ignored", 8'hC9);
    chk("R11 no drive", {6'd0, scl_oe, sda_oe}, 8'h00);

    // R7 R2: master receive mode start clears arbitration flag
    tb_ack_en = 1'b1; tx_data = 8'h91; exp_q.push_back(8'h91);
    wr(4'b1011);
    waitc(300);
    samp_stat("R7 R2 mode 10 start", 8'hB0);
    wr(4'b1001);
    waitc(60);
    samp_stat("R3 stop mode 10", 8'h90);

    chk("R2 queue drained", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule